// File: doc/BRIEF.md
# Phase Comparator with Lock Detection

This block sits in the digital core of a frequency synthesizer. It watches two pulse trains: the divided-down oscillator signal and the reference. From the order in which their rising edges arrive, it decides what the charge pump should do. The pump sources current while the divider edge is ahead and sinks current while it trails. It stays in high impedance when neither error is pending. Both pulse trains are sampled on the system clock, so phase error is measured in whole clock cycles.

A three-bit test code can replace the detector output with a fixed pump state. It can also hand a shared test pin over to either the reference or the divider signal. A separate bit picks the high or low pump current. A lock flag rises after a run of consecutive comparisons whose error pulse stays inside a small window. It drops as soon as any error grows past that window.

Top module: `phase_cmp_lock`

## Requirements
- R1: A divider rising edge that comes d clock cycles before the next reference rising edge drives `pumpSrcEn` high for exactly d cycles with `pumpSnkEn` low; the two enables are never high together.
- R2: A reference rising edge that comes d cycles before the divider rising edge drives `pumpSnkEn` high for exactly d cycles with `pumpSrcEn` low.
- R3: Rising edges on both inputs in the same cycle leave both enables low.
- R4: A second divider edge that arrives while the source state is pending keeps the source state (and no sink) until a reference edge arrives. After that both enables return low, so frequency error is detected.
- R5: `testCode` takes effect one cycle after it is applied. Code 00x (binary, MSB first) passes the detector through. Codes 01x, 100 and 101 hold both enables low. Code 110 holds `pumpSnkEn` high. Code 111 holds `pumpSrcEn` high.
- R6: Code 100 sets `testPinEn`=1 with `testPinSel`=0, which selects the reference. Code 101 sets `testPinEn`=1 with `testPinSel`=1, which selects the divider. Every other code gives `testPinEn`=0, which leaves the pin to the analog converter.
- R7: `pumpCurHigh` follows `cpHigh` one cycle later, where 1 means the high pump current and 0 the low one.
- R8: While `rstN` is low the outputs are as follows, whatever `testCode` and `cpHigh` are: both enables low, `pumpCurHigh`=1, `testPinEn`=0 and `lockFlag`=0.
- R9: `lockFlag` rises after LOCK_CNT (default 8) consecutive completed comparisons whose error width is at most LOCK_WIN cycles (default 2). It stays 0 after only LOCK_CNT-1 of them.
- R10: An error pulse that grows wider than LOCK_WIN cycles clears `lockFlag` on the next cycle, even before the comparison completes. It also restarts the run of good comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refIn | input | 1 | Reference pulse train |
| divIn | input | 1 | Divider output pulse train |
| testCode | input | 3 | Test code (bit 2 first) |
| cpHigh | input | 1 | Pump current select request |
| pumpSrcEn | output | 1 | Charge pump source enable |
| pumpSnkEn | output | 1 | Charge pump sink enable |
| pumpCurHigh | output | 1 | Selected pump current, 1 = high |
| testPinSel | output | 1 | Test pin source, 0 = reference, 1 = divider |
| testPinEn | output | 1 | Test pin driven by a digital signal |
| lockFlag | output | 1 | Loop lock indication |

## Verification
The bench measures the pump enable width in cycles for leads and lags of several sizes. A detector that clears its flip-flops one cycle late, or that swaps source and sink, shows up as an off-by-one width or a pulse on the wrong enable. It runs exactly LOCK_CNT-1 and then LOCK_CNT comparisons at an error equal to the window. An off-by-one lock count or a strict-versus-inclusive window mistake would show up there. It then sends a single wider error and then a divider-only burst. A design that waits for the comparison to finish before dropping lock, or that lets a repeated divider edge flip the state, is caught. Each test code is checked for both the forced pump state and the test pin routing.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic pumpHold;  // detector output masked
    logic forceSrc;  // source forced on
    logic forceSnk;  // sink forced on
    logic tpEn;      // test pin driven digitally
    logic tpSel;     // 0 reference, 1 divider
  } pumpCtl_t;

  localparam logic [1:0] GRP_NORMAL = 2'b00;
  localparam logic [1:0] GRP_HOLD   = 2'b01;
  localparam logic [1:0] GRP_PROBE  = 2'b10;
  localparam logic [1:0] GRP_FORCE  = 2'b11;

  localparam logic [2:0] CODE_AT_RESET = 3'b010;

endpackage

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
#(
  parameter int LOCK_CNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] testCode,
  input  logic       cpHigh,
  input  logic       cmpDone,
  input  logic       widthOver,
  output pumpCtl_t   ctl,
  output logic       curHigh,
  output logic       lockFlag
);

  localparam int GW = $clog2(LOCK_CNT + 1);

  logic [2:0]    codeReg;
  logic [GW-1:0] goodCnt;
  logic          goodPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= CODE_AT_RESET;
      curHigh <= 1'b1;
    end else begin
      codeReg <= testCode;
      curHigh <= cpHigh;
    end
  end

  always_comb begin
    ctl = '0;
    unique case (codeReg[2:1])
      GRP_NORMAL: ctl.pumpHold = 1'b0;
      GRP_HOLD:   ctl.pumpHold = 1'b1;
      GRP_PROBE: begin
        ctl.pumpHold = 1'b1;
        ctl.tpEn     = 1'b1;
        ctl.tpSel    = codeReg[0];
      end
      GRP_FORCE: begin
        ctl.pumpHold = 1'b1;
        ctl.forceSrc = codeReg[0];
        ctl.forceSnk = ~codeReg[0];
      end
      default: ctl = '0;
    endcase
  end

  assign goodPulse = cmpDone & ~widthOver;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (widthOver) begin
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (goodPulse) begin
      if (int'(goodCnt) < LOCK_CNT) goodCnt <= goodCnt + 1'b1;
      if (int'(goodCnt) + 1 >= LOCK_CNT) lockFlag <= 1'b1;
    end
  end

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    widthOver |=> !lockFlag); // R10

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(goodPulse)); // R9

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     refIn,
  input  logic     divIn,
  input  pumpCtl_t ctl,
  output logic     srcEn,
  output logic     snkEn,
  output logic     tpEn,
  output logic     tpSel,
  output logic     cmpDone,
  output logic     widthOver
);

  localparam int CNT_MAX = LOCK_WIN + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          refPrev, divPrev;
  logic          refEdge, divEdge;
  logic          srcFf, snkFf;
  logic          srcSet, snkSet;
  logic          errActive;
  logic [CW-1:0] widthCnt;

  assign refEdge = refIn & ~refPrev;
  assign divEdge = divIn & ~divPrev;

  assign srcSet  = srcFf | divEdge;
  assign snkSet  = snkFf | refEdge;
  assign cmpDone = srcSet & snkSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      divPrev <= 1'b0;
      srcFf   <= 1'b0;
      snkFf   <= 1'b0;
    end else begin
      refPrev <= refIn;
      divPrev <= divIn;
      srcFf   <= srcSet & ~cmpDone;
      snkFf   <= snkSet & ~cmpDone;
    end
  end

  assign errActive = srcFf | snkFf;
  assign widthOver = errActive && (int'(widthCnt) + 1 > LOCK_WIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (cmpDone || !errActive) begin
      widthCnt <= '0;
    end else if (widthCnt != CW'(CNT_MAX)) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign srcEn = ctl.forceSrc | (~ctl.pumpHold & srcFf);
  assign snkEn = ctl.forceSnk | (~ctl.pumpHold & snkFf);
  assign tpEn  = ctl.tpEn;
  assign tpSel = ctl.tpSel;

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(srcEn && snkEn)); // R1

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srcFf && !refEdge) |=> srcFf); // R4

  AST_FF_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(srcFf && snkFf)); // R3

endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN = 2,
  parameter int LOCK_CNT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       divIn,
  input  logic [2:0] testCode,
  input  logic       cpHigh,
  output logic       pumpSrcEn,
  output logic       pumpSnkEn,
  output logic       pumpCurHigh,
  output logic       testPinSel,
  output logic       testPinEn,
  output logic       lockFlag
);

  pumpCtl_t ctl;
  logic     cmpDone;
  logic     widthOver;

  pfd_control #(.LOCK_CNT(LOCK_CNT)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .testCode  (testCode),
    .cpHigh    (cpHigh),
    .cmpDone   (cmpDone),
    .widthOver (widthOver),
    .ctl       (ctl),
    .curHigh   (pumpCurHigh),
    .lockFlag  (lockFlag)
  );

  pfd_datapath #(.LOCK_WIN(LOCK_WIN)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .divIn     (divIn),
    .ctl       (ctl),
    .srcEn     (pumpSrcEn),
    .snkEn     (pumpSnkEn),
    .tpEn      (testPinEn),
    .tpSel     (testPinSel),
    .cmpDone   (cmpDone),
    .widthOver (widthOver)
  );

  AST_TP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    testPinEn |-> (!pumpSrcEn && !pumpSnkEn)); // R6

endmodule

// File: tb/sim_phase_cmp_lock.sv
`timescale 1ns/1ps
module sim_phase_cmp_lock;

  localparam int SAMPLES = 24;
  localparam int NVEC    = 10;

  typedef struct packed {
    logic [2:0]        code;
    logic              cp;
    logic signed [7:0] lead;
    logic [7:0]        expSrc;
    logic [7:0]        expSnk;
    logic              expTpEn;
    logic              expTpSel;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 1'b1,  8'sd3, 8'd3,  8'd0,  1'b0, 1'b0}, // R1 R7
    '{3'b000, 1'b0, -8'sd4, 8'd0,  8'd4,  1'b0, 1'b0}, // R2 R7
    '{3'b000, 1'b1,  8'sd0, 8'd0,  8'd0,  1'b0, 1'b0}, // R3
    '{3'b000, 1'b0,  8'sd1, 8'd1,  8'd0,  1'b0, 1'b0}, // R1
    '{3'b010, 1'b1,  8'sd3, 8'd0,  8'd0,  1'b0, 1'b0}, // R5
    '{3'b011, 1'b0, -8'sd3, 8'd0,  8'd0,  1'b0, 1'b0}, // R5
    '{3'b110, 1'b1,  8'sd3, 8'd0,  8'd24, 1'b0, 1'b0}, // R5
    '{3'b111, 1'b0, -8'sd3, 8'd24, 8'd0,  1'b0, 1'b0}, // R5
    '{3'b100, 1'b1,  8'sd3, 8'd0,  8'd0,  1'b1, 1'b0}, // R6
    '{3'b101, 1'b0, -8'sd2, 8'd0,  8'd0,  1'b1, 1'b1}  // R6
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic       divIn = 1'b0;
  logic [2:0] testCode = 3'b000;
  logic       cpHigh = 1'b0;
  logic       pumpSrcEn, pumpSnkEn, pumpCurHigh, testPinSel, testPinEn, lockFlag;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  phase_cmp_lock u0 (
    .clk(clk), .rstN(rstN), .refIn(refIn), .divIn(divIn),
    .testCode(testCode), .cpHigh(cpHigh),
    .pumpSrcEn(pumpSrcEn), .pumpSnkEn(pumpSnkEn), .pumpCurHigh(pumpCurHigh),
    .testPinSel(testPinSel), .testPinEn(testPinEn), .lockFlag(lockFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs SAMPLES cycles with one pulse on each input; lead > 0 puts divider first
  task automatic runPair(input int lead, output int srcCnt, output int snkCnt);
    int divAt, refAt;
    divAt = (lead >= 0) ? 2 : 2 - lead;
    refAt = (lead >= 0) ? 2 + lead : 2;
    srcCnt = 0;
    snkCnt = 0;
    for (int i = 0; i < SAMPLES; i++) begin
      @(negedge clk);
      srcCnt += int'(pumpSrcEn);
      snkCnt += int'(pumpSnkEn);
      divIn = (i >= divAt) && (i < divAt + 2);
      refIn = (i >= refAt) && (i < refAt + 2);
    end
  endtask

  initial begin
    int s, k;
    // Reset state, with inputs set to values that would otherwise change outputs
    testCode = 3'b111;
    cpHigh   = 1'b0;
    repeat (4) @(negedge clk);
    check(!pumpSrcEn && !pumpSnkEn, "R8 pump off", int'(pumpSrcEn) + int'(pumpSnkEn), 0);
    check(pumpCurHigh == 1'b1, "R8 high current", int'(pumpCurHigh), 1);
    check(testPinEn == 1'b0, "R8 test pin", int'(testPinEn), 0);
    check(lockFlag == 1'b0, "R8 lock", int'(lockFlag), 0);
    testCode = 3'b000;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      testCode = VECS[v].code;
      cpHigh   = VECS[v].cp;
      repeat (2) @(negedge clk);
      runPair(int'(VECS[v].lead), s, k);
      check(s == int'(VECS[v].expSrc), $sformatf("vec %0d R1/R5 source cycles", v), s, int'(VECS[v].expSrc));
      check(k == int'(VECS[v].expSnk), $sformatf("vec %0d R2/R5 sink cycles", v), k, int'(VECS[v].expSnk));
      check(testPinEn == VECS[v].expTpEn, $sformatf("vec %0d R6 test pin enable", v),
            int'(testPinEn), int'(VECS[v].expTpEn));
      if (VECS[v].expTpEn)
        check(testPinSel == VECS[v].expTpSel, $sformatf("vec %0d R6 test pin select", v),
              int'(testPinSel), int'(VECS[v].expTpSel));
      check(pumpCurHigh == VECS[v].cp, $sformatf("vec %0d R7 current", v),
            int'(pumpCurHigh), int'(VECS[v].cp));
    end

    // Lock acquisition at an error equal to the window (R9)
    @(negedge clk);
    testCode = 3'b000;
    repeat (2) @(negedge clk);
    runPair(3, s, k); // wider than window: restart the run (R10)
    for (int p = 0; p < 7; p++) runPair(2, s, k);
    check(lockFlag == 1'b0, "R9 no lock after LOCK_CNT-1", int'(lockFlag), 0);
    runPair(2, s, k);
    check(lockFlag == 1'b1, "R9 lock after LOCK_CNT", int'(lockFlag), 1);

    // One wide error drops lock (R10)
    runPair(3, s, k);
    check(lockFlag == 1'b0, "R10 wide error clears lock", int'(lockFlag), 0);
    for (int p = 0; p < 8; p++) runPair(-1, s, k);
    check(lockFlag == 1'b1, "R9 relock with lagging divider", int'(lockFlag), 1);

    // Divider-only burst: lock drops before any reference edge (R10), source held (R4)
    @(negedge clk); divIn = 1'b1;
    @(negedge clk);
    @(negedge clk); divIn = 1'b0;
    repeat (3) @(negedge clk);
    check(lockFlag == 1'b0, "R10 clear before compare ends", int'(lockFlag), 0);
    check(pumpSrcEn == 1'b1, "R4 source pending", int'(pumpSrcEn), 1);
    @(negedge clk); divIn = 1'b1;
    @(negedge clk);
    @(negedge clk); divIn = 1'b0;
    @(negedge clk);
    check(pumpSrcEn == 1'b1 && pumpSnkEn == 1'b0, "R4 second divider edge keeps source",
          int'(pumpSnkEn), 0);
    @(negedge clk); refIn = 1'b1;
    @(negedge clk);
    @(negedge clk); refIn = 1'b0;
    check(!pumpSrcEn && !pumpSnkEn, "R4 reference edge ends error",
          int'(pumpSrcEn) + int'(pumpSnkEn), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule